// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Register Core

This core holds a wall-clock time and calendar as a set of byte-wide BCD registers: seconds, minutes, hours in 24-hour form, day of week, day of month, month and two-digit year. A one-cycle pulse on the 1 Hz tick input advances the time by one second. The seconds-to-year carry chain follows month lengths, including a leap-year February. Software sets or changes any register through a simple write port that carries an address and a data byte. Every register is visible on the outputs at all times.

Three control bits sit in spare register bits. An oscillator-halt bit in the seconds register freezes the clock. A century-enable bit and a century bit sit in the hours register, and the century bit flips on each year wrap while the enable is set. A separate flag register holds a sticky oscillator-stopped indication. It comes up set, it is set again whenever the effective oscillator stops, and software can only clear it. A write to the seconds register also emits a one-cycle pulse, which an external prescaler uses to restart its count.

Top module: `rtc_calendar_core`

## Requirements
- R1: After reset, the register outputs read: seconds 00 with the halt bit 0, minutes 00, hours 00 with both century bits 0, day of week 01, date 01, month 01, year 00, and flag register 8'h80.
- R2: When a tick arrives and no write is pending, seconds advance by one in BCD. Seconds wrap 59->00 and carry into minutes. Minutes wrap 59->00 and carry into hours. Hours wrap 23->00.
- R3: On the 23:59:59 -> 00:00:00 step, day of week increments, and it wraps from 07 to 01.
- R4: At midnight the date wraps to 01 and the month advances after the last day of the month. The last day is 30 for months 04, 06, 09 and 11, 28 or 29 for month 02, and 31 for all other months.
- R5: A year whose value is divisible by 4 is a leap year, and year 00 counts as one. In a leap year February runs to 29.
- R6: Month 12 wraps to 01 and carries into the year. Year 99 wraps to 00.
- R7: On the year 99->00 wrap, hours bit 6 (century) toggles only if hours bit 7 (century enable) is 1.
- R8: While seconds bit 7 (oscillator halt) is 1, ticks are ignored and no time register changes.
- R9: Flag bit 7 is set in the cycle after the effective oscillator goes from running to stopped. The effective oscillator is osc_running high and the halt bit 0. The flag then stays set until software clears it.
- R10: A write to address 7 clears the flag when data bit 7 is 0, and leaves it unchanged when data bit 7 is 1. Flag bits 6:0 always read 0. If a stop event and a clearing write fall in the same cycle, the flag stays set.
- R11: A write takes effect at the next edge. The addresses are 0 sec, 1 min, 2 hour, 3 day of week, 4 date, 5 month and 6 year. Bits with no field read back as 0: minutes bit 7, day-of-week bits 7:3, date bits 7:6 and month bits 7:5.
- R12: If a write and a tick fall in the same cycle, the write is stored and the tick is discarded, so no field advances.
- R13: A write to address 0 drives div_reset high for exactly the one cycle after the write edge. Writes to other addresses leave it low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_1hz | input | 1 | One-cycle pulse once per second |
| osc_running | input | 1 | High while the timebase oscillator runs |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| sec_reg | output | 8 | Halt bit 7, BCD seconds 6:0 |
| min_reg | output | 8 | BCD minutes |
| hour_reg | output | 8 | Century enable 7, century 6, BCD hours 5:0 |
| dow_reg | output | 8 | Day of week 1..7 |
| date_reg | output | 8 | BCD day of month |
| month_reg | output | 8 | BCD month |
| year_reg | output | 8 | BCD year |
| flag_reg | output | 8 | Oscillator-stopped flag in bit 7 |
| div_reset | output | 1 | One-cycle prescaler restart pulse |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a tick and a register write. The bench raises both in one cycle and expects the written field to hold the write data and every other field to stay unchanged. The second pair is a stop event on the flag and a clearing write to the flag. The bench drops osc_running in the same cycle as a write of 0 to address 7 and expects the flag still set afterwards. Carry-chain corners are driven by loading the registers one second before a month, year or century boundary and issuing a single tick.

// File: rtl/rtc_cal_pkg.sv
`timescale 1ns/1ps
// Shared widths, field indices and BCD helpers for the calendar core.
// Assumes all fields are two-digit packed BCD in one byte.
package rtc_cal_pkg;
    localparam int BYTE_W  = 8;
    localparam int ADDR_W  = 3;
    localparam int NFIELD  = 7;

    localparam int F_SEC   = 0;
    localparam int F_MIN   = 1;
    localparam int F_HOUR  = 2;
    localparam int F_DOW   = 3;
    localparam int F_DATE  = 4;
    localparam int F_MONTH = 5;
    localparam int F_YEAR  = 6;
    localparam int F_FLAG  = 7;

    // Add one to a packed two-digit BCD value (no range wrap here).
    function automatic logic [BYTE_W-1:0] bcd_inc(input logic [BYTE_W-1:0] v);
        if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
        else                return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // Convert a packed two-digit BCD value to binary.
    function automatic logic [6:0] bcd_to_bin(input logic [BYTE_W-1:0] v);
        return 7'(v[7:4]) * 7'd10 + 7'(v[3:0]);
    endfunction
endpackage

// File: rtl/rtc_bcd_step.sv
`timescale 1ns/1ps
// One BCD field step: the next value and a wrap indication.
// Assumes cur lies within [first, last]. Purely combinational.
module rtc_bcd_step
    import rtc_cal_pkg::*;
(
    input  logic [BYTE_W-1:0] cur,
    input  logic [BYTE_W-1:0] first,
    input  logic [BYTE_W-1:0] last,
    output logic [BYTE_W-1:0] nxt,
    output logic              wrap
);
    // Wrap to first at last, otherwise BCD increment.
    always_comb begin
        wrap = (cur == last);
        nxt  = wrap ? first : bcd_inc(cur);
    end
endmodule

// File: rtl/rtc_month_end.sv
`timescale 1ns/1ps
// Last valid BCD date of a month, with leap years being those divisible by 4.
// Assumes month and year are legal BCD.
module rtc_month_end
    import rtc_cal_pkg::*;
(
    input  logic [BYTE_W-1:0] month,
    input  logic [BYTE_W-1:0] year,
    output logic [BYTE_W-1:0] last_date
);
    logic [6:0] year_bin;
    logic       leap;

    // Decode month length from month number and leap status.
    always_comb begin
        year_bin = bcd_to_bin(year);
        leap     = (year_bin[1:0] == 2'b00);
        case (month)
            8'h02:                      last_date = leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: last_date = 8'h30;
            default:                    last_date = 8'h31;
        endcase
    end
endmodule

// File: rtl/rtc_stop_flag.sv
`timescale 1ns/1ps
// Sticky oscillator-stopped flag: set on a run->stop edge and at reset,
// cleared only by request. A set event outranks a clear in the same cycle.
module rtc_stop_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_ok,
    input  logic clr_req,
    output logic flag
);
    logic osc_ok_q;

    // Track the previous oscillator state and update the flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            osc_ok_q <= 1'b0;
            flag     <= 1'b1;
        end else begin
            osc_ok_q <= osc_ok;
            if (osc_ok_q && !osc_ok) flag <= 1'b1;
            else if (clr_req)        flag <= 1'b0;
        end
    end
endmodule

// File: rtl/rtc_calendar_core.sv
`timescale 1ns/1ps
// BCD time and calendar register core with a century toggle, an oscillator
// halt bit and a sticky stop flag. Assumes tick_1hz is a single-cycle pulse
// and that software writes only legal BCD values.
module rtc_calendar_core
    import rtc_cal_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1hz,
    input  logic              osc_running,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] sec_reg,
    output logic [BYTE_W-1:0] min_reg,
    output logic [BYTE_W-1:0] hour_reg,
    output logic [BYTE_W-1:0] dow_reg,
    output logic [BYTE_W-1:0] date_reg,
    output logic [BYTE_W-1:0] month_reg,
    output logic [BYTE_W-1:0] year_reg,
    output logic [BYTE_W-1:0] flag_reg,
    output logic              div_reset
);
    logic [BYTE_W-1:0] field_q  [NFIELD];
    logic [BYTE_W-1:0] field_nx [NFIELD];
    logic [NFIELD-1:0] wrap;
    logic [NFIELD-1:0] adv;
    logic [BYTE_W-1:0] month_last;
    logic              halt_q, cen_en_q, cen_q, flag_q;
    logic              tick_en, cen_flip;

    // Ticks count only when the clock runs and no write is pending.
    assign tick_en  = tick_1hz && !halt_q && !wr_en;

    // Ripple the carry from seconds up to the year.
    always_comb begin
        adv[F_SEC]   = tick_en;
        adv[F_MIN]   = adv[F_SEC]   && wrap[F_SEC];
        adv[F_HOUR]  = adv[F_MIN]   && wrap[F_MIN];
        adv[F_DOW]   = adv[F_HOUR]  && wrap[F_HOUR];
        adv[F_DATE]  = adv[F_HOUR]  && wrap[F_HOUR];
        adv[F_MONTH] = adv[F_DATE]  && wrap[F_DATE];
        adv[F_YEAR]  = adv[F_MONTH] && wrap[F_MONTH];
    end
    assign cen_flip = adv[F_YEAR] && wrap[F_YEAR] && cen_en_q;

    rtc_month_end u_month_end (
        .month     (field_q[F_MONTH]),
        .year      (field_q[F_YEAR]),
        .last_date (month_last)
    );

    for (genvar i = 0; i < NFIELD; i++) begin : g_field
        localparam logic [BYTE_W-1:0] FIRST =
            (i == F_DOW || i == F_DATE || i == F_MONTH) ? 8'h01 : 8'h00;
        localparam logic [BYTE_W-1:0] LAST_FIX =
            (i == F_SEC || i == F_MIN) ? 8'h59 :
            (i == F_HOUR)              ? 8'h23 :
            (i == F_DOW)               ? 8'h07 :
            (i == F_MONTH)             ? 8'h12 : 8'h99;
        localparam logic [BYTE_W-1:0] MASK =
            (i == F_SEC || i == F_MIN)   ? 8'h7F :
            (i == F_HOUR || i == F_DATE) ? 8'h3F :
            (i == F_DOW)                 ? 8'h07 :
            (i == F_MONTH)               ? 8'h1F : 8'hFF;

        logic [BYTE_W-1:0] last_v;
        if (i == F_DATE) begin : g_dyn
            assign last_v = month_last;
        end else begin : g_fix
            assign last_v = LAST_FIX;
        end

        rtc_bcd_step u_step (
            .cur   (field_q[i]),
            .first (FIRST),
            .last  (last_v),
            .nxt   (field_nx[i]),
            .wrap  (wrap[i])
        );

        // Field register: a write wins over a carry advance.
        always_ff @(posedge clk) begin
            if (!rst_n)
                field_q[i] <= FIRST;
            else if (wr_en && wr_addr == ADDR_W'(i))
                field_q[i] <= wr_data & MASK;
            else if (adv[i])
                field_q[i] <= field_nx[i];
        end
    end

    // Control bits held in spare bits of seconds and hours.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            halt_q   <= 1'b0;
            cen_en_q <= 1'b0;
            cen_q    <= 1'b0;
        end else if (wr_en && wr_addr == ADDR_W'(F_SEC)) begin
            halt_q   <= wr_data[7];
        end else if (wr_en && wr_addr == ADDR_W'(F_HOUR)) begin
            cen_en_q <= wr_data[7];
            cen_q    <= wr_data[6];
        end else if (cen_flip) begin
            cen_q    <= ~cen_q;
        end
    end

    // Prescaler restart pulse after a seconds write.
    always_ff @(posedge clk) begin
        if (!rst_n) div_reset <= 1'b0;
        else        div_reset <= wr_en && (wr_addr == ADDR_W'(F_SEC));
    end

    rtc_stop_flag u_stop_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .osc_ok  (osc_running && !halt_q),
        .clr_req (wr_en && wr_addr == ADDR_W'(F_FLAG) && !wr_data[7]),
        .flag    (flag_q)
    );

    // Assemble the visible register bytes.
    always_comb begin
        sec_reg   = {halt_q, field_q[F_SEC][6:0]};
        min_reg   = field_q[F_MIN];
        hour_reg  = {cen_en_q, cen_q, field_q[F_HOUR][5:0]};
        dow_reg   = field_q[F_DOW];
        date_reg  = field_q[F_DATE];
        month_reg = field_q[F_MONTH];
        year_reg  = field_q[F_YEAR];
        flag_reg  = {flag_q, 7'b0};
    end
endmodule

// File: rtl/rtc_calendar_core_chk.sv
`timescale 1ns/1ps
// Property checker for rtc_calendar_core, attached by bind below.
module rtc_calendar_core_chk
    import rtc_cal_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              tick_1hz,
    input logic              osc_running,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [BYTE_W-1:0] wr_data,
    input logic [BYTE_W-1:0] sec_reg,
    input logic [BYTE_W-1:0] min_reg,
    input logic [BYTE_W-1:0] hour_reg,
    input logic [BYTE_W-1:0] dow_reg,
    input logic [BYTE_W-1:0] date_reg,
    input logic [BYTE_W-1:0] month_reg,
    input logic [BYTE_W-1:0] year_reg,
    input logic [BYTE_W-1:0] flag_reg,
    input logic              div_reset
);
    logic eff_run;
    assign eff_run = osc_running && !sec_reg[7];

    p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_reg[7] && !(wr_en && wr_addr == 3'd7 && !wr_data[7])) |=> flag_reg[7]);

    p_stop_sets_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(eff_run) |=> flag_reg[7]);

    p_flag_low_bits_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flag_reg[6:0] == 7'b0);

    p_halt_freezes_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_reg[7] && !wr_en) |=> ($stable(sec_reg) && $stable(min_reg) && $stable(hour_reg)
                                    && $stable(date_reg) && $stable(year_reg)));

    p_century_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !hour_reg[7]) |=> (hour_reg[6] == $past(hour_reg[6])));

    p_write_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 3'd1) |=> (min_reg == {1'b0, $past(wr_data[6:0])}));

    p_divrst_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 3'd0) |=> div_reset);

    p_divrst_cause_r13: assert property (@(posedge clk) disable iff (!rst_n)
        div_reset |-> $past(wr_en && wr_addr == 3'd0));
endmodule

bind rtc_calendar_core rtc_calendar_core_chk chk_i (.*);

// File: tb/rtc_calendar_core_tb_top.sv
`timescale 1ns/1ps
// Directed bench for rtc_calendar_core, one task per scenario.
module rtc_calendar_core_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_1hz = 1'b0;
    logic       osc_running = 1'b1;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = 3'd0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] sec_reg, min_reg, hour_reg, dow_reg, date_reg, month_reg, year_reg, flag_reg;
    logic       div_reset;
    int         n_chk = 0;
    int         n_bad = 0;

    always #10 clk = ~clk;

    rtc_calendar_core dut_i (
        .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .osc_running(osc_running),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .sec_reg(sec_reg), .min_reg(min_reg), .hour_reg(hour_reg), .dow_reg(dow_reg),
        .date_reg(date_reg), .month_reg(month_reg), .year_reg(year_reg),
        .flag_reg(flag_reg), .div_reset(div_reset)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic tick1();
        tick_1hz = 1'b1;
        step();
        tick_1hz = 1'b0;
    endtask

    task automatic load(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
                        input logic [7:0] dw, input logic [7:0] dt, input logic [7:0] mo,
                        input logic [7:0] yr);
        wr(3'd6, yr); wr(3'd5, mo); wr(3'd4, dt); wr(3'd3, dw);
        wr(3'd2, h);  wr(3'd1, m);  wr(3'd0, s);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        step(); step();
        check("R1 sec", sec_reg, 8'h00);   check("R1 min", min_reg, 8'h00);
        check("R1 hour", hour_reg, 8'h00); check("R1 dow", dow_reg, 8'h01);
        check("R1 date", date_reg, 8'h01); check("R1 month", month_reg, 8'h01);
        check("R1 year", year_reg, 8'h00); check("R1 flag", flag_reg, 8'h80);
        rst_n = 1'b1;
        step();
    endtask

    task automatic t_seconds();
        load(8'h08, 8'h14, 8'h09, 8'h02, 8'h10, 8'h06, 8'h21);
        tick1(); check("R2 sec 08->09", sec_reg, 8'h09);
        tick1(); check("R2 sec 09->10", sec_reg, 8'h10);
        step();  check("R2 no tick holds", sec_reg, 8'h10);
        load(8'h59, 8'h59, 8'h09, 8'h02, 8'h10, 8'h06, 8'h21);
        tick1();
        check("R2 sec wrap", sec_reg, 8'h00);
        check("R2 min wrap", min_reg, 8'h00);
        check("R2 hour carry", hour_reg, 8'h10);
        check("R3 dow unchanged", dow_reg, 8'h02);
    endtask

    task automatic t_year_end(input logic [7:0] hr, input logic [7:0] exp_hr, input string tag);
        load(8'h59, 8'h59, hr, 8'h07, 8'h31, 8'h12, 8'h99);
        tick1();
        check({"R2 sec ", tag}, sec_reg, 8'h00);
        check({"R7 hour/century ", tag}, hour_reg, exp_hr);
        check({"R3 dow wrap ", tag}, dow_reg, 8'h01);
        check({"R4 date ", tag}, date_reg, 8'h01);
        check({"R6 month ", tag}, month_reg, 8'h01);
        check({"R6 year ", tag}, year_reg, 8'h00);
    endtask

    task automatic t_month(input logic [7:0] mo, input logic [7:0] yr, input logic [7:0] dt,
                           input logic [7:0] exp_mo, input logic [7:0] exp_dt, input string req);
        load(8'h59, 8'h59, 8'h23, 8'h03, dt, mo, yr);
        tick1();
        check({req, " date"}, date_reg, exp_dt);
        check({req, " month"}, month_reg, exp_mo);
        check("R3 dow step", dow_reg, 8'h04);
    endtask

    task automatic t_halt_and_flag();
        wr(3'd7, 8'h00);
        check("R10 clear", flag_reg, 8'h00);
        wr(3'd0, 8'h90);
        step();
        check("R9 halt sets flag", flag_reg, 8'h80);
        tick1(); tick1(); tick1();
        check("R8 halted sec", sec_reg, 8'h90);
        wr(3'd0, 8'h10);
        wr(3'd7, 8'h00);
        tick1();
        check("R8 resumed", sec_reg, 8'h11);
        check("R10 cleared", flag_reg, 8'h00);
    endtask

    task automatic t_flag_write();
        wr(3'd7, 8'hFF);
        check("R10 write 1 keeps 0", flag_reg, 8'h00);
        osc_running = 1'b0;
        step(); step();
        check("R9 osc stop", flag_reg, 8'h80);
        wr(3'd7, 8'hFF);
        check("R10 write 1 keeps 1", flag_reg, 8'h80);
        osc_running = 1'b1;
        step();
        check("R9 sticky on restart", flag_reg, 8'h80);
        wr(3'd7, 8'h7F);
        check("R10 bit7=0 clears", flag_reg, 8'h00);
        osc_running = 1'b0;
        wr(3'd7, 8'h00);
        check("R10 set beats clear", flag_reg, 8'h80);
        osc_running = 1'b1;
        step();
        wr(3'd7, 8'h00);
    endtask

    task automatic t_collide();
        load(8'h10, 8'h20, 8'h05, 8'h01, 8'h15, 8'h03, 8'h30);
        tick_1hz = 1'b1;
        wr(3'd1, 8'h33);
        tick_1hz = 1'b0;
        check("R12 write stored", min_reg, 8'h33);
        check("R12 tick discarded", sec_reg, 8'h10);
    endtask

    task automatic t_masks();
        wr(3'd1, 8'hD9); check("R11 min mask", min_reg, 8'h59);
        wr(3'd3, 8'hFB); check("R11 dow mask", dow_reg, 8'h03);
        wr(3'd4, 8'hF1); check("R11 date mask", date_reg, 8'h31);
        wr(3'd5, 8'hF2); check("R11 month mask", month_reg, 8'h12);
        wr(3'd6, 8'h47); check("R11 year", year_reg, 8'h47);
    endtask

    task automatic t_divrst();
        wr(3'd0, 8'h05);
        check("R13 pulse high", {7'b0, div_reset}, 8'h01);
        step();
        check("R13 pulse ends", {7'b0, div_reset}, 8'h00);
        wr(3'd1, 8'h05);
        check("R13 other addr low", {7'b0, div_reset}, 8'h00);
    endtask

    initial begin
        #(20 * 200000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_seconds();
        t_year_end(8'h23, 8'h00, "no century");
        t_year_end(8'hA3, 8'hC0, "century 0->1");
        t_year_end(8'hE3, 8'h80, "century 1->0");
        t_month(8'h04, 8'h21, 8'h30, 8'h05, 8'h01, "R4 april");
        t_month(8'h01, 8'h21, 8'h30, 8'h01, 8'h31, "R4 jan 30");
        t_month(8'h01, 8'h21, 8'h31, 8'h02, 8'h01, "R4 jan 31");
        t_month(8'h02, 8'h23, 8'h28, 8'h03, 8'h01, "R4 feb common");
        t_month(8'h02, 8'h24, 8'h28, 8'h02, 8'h29, "R5 feb leap 24");
        t_month(8'h02, 8'h24, 8'h29, 8'h03, 8'h01, "R5 feb29 end");
        t_month(8'h02, 8'h00, 8'h28, 8'h02, 8'h29, "R5 year 00 leap");
        t_month(8'h11, 8'h21, 8'h30, 8'h12, 8'h01, "R4 november");
        t_halt_and_flag();
        t_flag_write();
        t_collide();
        t_masks();
        t_divrst();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule